// File: doc/BRIEF.md
# SD Card SPI Command Sequencer

This block issues one command to a memory card that runs in SPI mode and collects the card's one-byte status reply. A request carries a 6-bit command index, a 32-bit argument and two mode flags. The block selects the card, sends a six-byte command frame through a byte-exchange port, and then keeps clocking out idle bytes until the card returns a byte whose top bit is clear. Each exchange is a handshake: the block pulses `xfer_start` with a byte to send, and the byte-serial shifter answers with `xfer_done` and the byte it received.

Two flags shape the end of the transaction. The extended flag makes the block read four more bytes after the status byte and pack them into a 32-bit word, most significant byte first. This is the form of the operating-conditions reply and of the interface-condition echo. The keep flag leaves the card selected after a good reply, so that a data block can follow. Without it, the block releases chip select and clocks one more idle byte. A reply that never arrives within the poll limit ends as a timeout, and the card is always released in that case.

The status byte is returned unchanged. Its flags are: bit 6 parameter error, bit 5 address error, bit 4 erase sequence error, bit 3 command CRC error, bit 2 illegal command, bit 1 erase reset, and bit 0 in idle state.

Top module: `sdspi_cmd_unit`

## Requirements
- R1: `cs_n` goes low when a request is accepted, before the first frame exchange starts. It stays low for every frame, poll and extended exchange of that command.
- R2: The first frame byte is 0x40 OR the command index, so its bits 7:6 are 01 and bits 5:0 carry the index.
- R3: Frame bytes 2 to 5 are the argument, most significant byte first. Byte 6 is the CRC byte: 0x87 when the index is 8, and 0x95 for every other index.
- R4: After the frame, every exchange sends 0xFF. The reply is the first received byte with bit 7 equal to 0. Received bytes with bit 7 set are skipped, whatever their other bits hold. The reply is presented unchanged on `resp_r1`.
- R5: If none of the first POLL_LIMIT (default 5000) poll exchanges returns a byte with bit 7 clear, `timed_out` is 1 at `done` and no further poll exchange is made.
- R6: With keep clear, after a reply (or a timeout) `cs_n` rises and exactly one more exchange of 0xFF is made with `cs_n` high. `done` follows that exchange.
- R7: With keep set and a reply received, `cs_n` stays low, no trailing exchange is made, and `done` follows the last reply or extended byte.
- R8: With keep set and a timeout, the card is still released: `cs_n` is high and one trailing 0xFF exchange is made.
- R9: With the extended flag set, four exchanges follow the reply byte. Their received bytes appear on `resp_ext`, with the first one in bits 31:24.
- R10: At most one exchange is outstanding: `xfer_start` is not raised again until `xfer_done` has answered the previous one.
- R11: After reset, `cs_n` is 1 and `busy`, `done` and `xfer_start` are 0. `done` is a single-cycle pulse, and `busy` is 0 from that cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a command; taken when `busy` is 0 |
| req_index | input | 6 | Command index |
| req_arg | input | 32 | Command argument |
| req_ext | input | 1 | Read four extra bytes after the reply |
| req_keep | input | 1 | Keep the card selected after a good reply |
| busy | output | 1 | Command in progress |
| xfer_start | output | 1 | Start a byte exchange (one-cycle pulse) |
| xfer_tx | output | 8 | Byte to send, valid with `xfer_start` |
| xfer_done | input | 1 | Exchange finished, `xfer_rx` valid |
| xfer_rx | input | 8 | Byte received by the exchange |
| cs_n | output | 1 | Card chip select, active low |
| done | output | 1 | Command finished (one-cycle pulse) |
| resp_r1 | output | 8 | Reply status byte |
| resp_ext | output | 32 | Four extra reply bytes, first in bits 31:24 |
| timed_out | output | 1 | No reply within the poll limit |

## Verification
The hardest case to reach is the edge of the poll window. A reply that arrives on exactly the last permitted poll must be accepted. A reply one exchange later must give a timeout with exactly one trailing release byte, and this must hold in both keep modes. The bench's card model returns a programmable number of filler bytes with bit 7 set before the reply. That count is set to POLL_LIMIT-1 and to POLL_LIMIT, and the exchanges are counted together with the chip-select level at each one. A sweep over all 64 indices varies the filler pattern, the reply value, the extended flag and the handshake latency.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int          FRAME_LEN   = 6;
    localparam logic [7:0]  FILL_BYTE   = 8'hFF;
    localparam logic [7:0]  CRC_PLAIN   = 8'h95;
    localparam logic [7:0]  CRC_IFCOND  = 8'h87;
    localparam logic [5:0]  IFCOND_IDX  = 6'd8;
    localparam logic [1:0]  START_BITS  = 2'b01;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FRAME,
        PH_POLL,
        PH_EXT,
        PH_TAIL
    } phase_t;

    typedef struct packed {
        logic [5:0]  index;
        logic [31:0] arg;
        logic        want_ext;
        logic        keep_sel;
    } cmd_req_t;

    function automatic logic [7:0] pick_crc(input logic [5:0] index);
        return (index == IFCOND_IDX) ? CRC_IFCOND : CRC_PLAIN;
    endfunction

    function automatic logic [7:0] frame_byte(input cmd_req_t r, input logic [2:0] pos);
        logic [7:0] b;
        case (pos)
            3'd0:    b = {START_BITS, r.index};
            3'd1:    b = r.arg[31:24];
            3'd2:    b = r.arg[23:16];
            3'd3:    b = r.arg[15:8];
            3'd4:    b = r.arg[7:0];
            3'd5:    b = pick_crc(r.index);
            default: b = FILL_BYTE;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/sdspi_frame_mux.sv
module sdspi_frame_mux
    import sdcmd_pkg::*;
(
    input  cmd_req_t   req,
    input  logic [2:0] pos,
    output logic [7:0] byte_out
);
    always_comb byte_out = frame_byte(req, pos);
endmodule

// File: rtl/sdspi_poll_count.sv
module sdspi_poll_count #(
    parameter int LIMIT = 5000,
    localparam int CW = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          step,
    output logic [CW-1:0] count,
    output logic          last
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            count <= '0;
        else if (step && count != CW'(LIMIT))
            count <= count + 1'b1;
    end

    assign last = (count == CW'(LIMIT - 1));
endmodule

// File: rtl/sdspi_ext_shift.sv
module sdspi_ext_shift #(
    parameter int NBYTES = 4,
    localparam int W = 8 * NBYTES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         step,
    input  logic [7:0]   din,
    output logic [W-1:0] word
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            word <= '0;
        else if (step)
            word <= {word[W-9:0], din};
    end
endmodule

// File: rtl/sdspi_cmd_unit.sv
module sdspi_cmd_unit
    import sdcmd_pkg::*;
#(
    parameter int POLL_LIMIT = 5000,
    parameter int EXT_BYTES  = 4,
    localparam int PCW = $clog2(POLL_LIMIT + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic [5:0]             req_index,
    input  logic [31:0]            req_arg,
    input  logic                   req_ext,
    input  logic                   req_keep,
    output logic                   busy,
    output logic                   xfer_start,
    output logic [7:0]             xfer_tx,
    input  logic                   xfer_done,
    input  logic [7:0]             xfer_rx,
    output logic                   cs_n,
    output logic                   done,
    output logic [7:0]             resp_r1,
    output logic [8*EXT_BYTES-1:0] resp_ext,
    output logic                   timed_out
);
    phase_t     phase;
    cmd_req_t   req_q;
    logic [2:0] pos_q;
    logic       pend_q, start_q, cs_q, done_q, to_q;
    logic [7:0] tx_q, r1_q;
    logic [7:0] frame_out;
    logic [PCW-1:0] poll_cnt;
    logic       poll_last;
    logic       accept, handshake, poll_step, ext_step, reply_seen;

    assign accept     = (phase == PH_IDLE) && req_valid;
    assign handshake  = (phase != PH_IDLE) && pend_q && xfer_done;
    assign poll_step  = handshake && (phase == PH_POLL);
    assign ext_step   = handshake && (phase == PH_EXT);
    assign reply_seen = !xfer_rx[7];

    sdspi_frame_mux u_frame (
        .req      (req_q),
        .pos      (pos_q),
        .byte_out (frame_out)
    );

    sdspi_poll_count #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .step  (poll_step),
        .count (poll_cnt),
        .last  (poll_last)
    );

    sdspi_ext_shift #(.NBYTES(EXT_BYTES)) u_ext (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .step  (ext_step),
        .din   (xfer_rx),
        .word  (resp_ext)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            req_q   <= '0;
            pos_q   <= '0;
            pend_q  <= 1'b0;
            start_q <= 1'b0;
            tx_q    <= FILL_BYTE;
            cs_q    <= 1'b1;
            done_q  <= 1'b0;
            to_q    <= 1'b0;
            r1_q    <= FILL_BYTE;
        end else begin
            start_q <= 1'b0;
            done_q  <= 1'b0;
            if (phase == PH_IDLE) begin
                if (req_valid) begin
                    req_q <= '{index: req_index, arg: req_arg,
                               want_ext: req_ext, keep_sel: req_keep};
                    cs_q  <= 1'b0;
                    to_q  <= 1'b0;
                    pos_q <= '0;
                    phase <= PH_FRAME;
                end
            end else if (!pend_q) begin
                start_q <= 1'b1;
                pend_q  <= 1'b1;
                tx_q    <= (phase == PH_FRAME) ? frame_out : FILL_BYTE;
            end else if (xfer_done) begin
                pend_q <= 1'b0;
                case (phase)
                    PH_FRAME: begin
                        if (pos_q == 3'(FRAME_LEN - 1)) phase <= PH_POLL;
                        else                            pos_q <= pos_q + 1'b1;
                    end
                    PH_POLL: begin
                        if (reply_seen) begin
                            r1_q <= xfer_rx;
                            if (req_q.want_ext) begin
                                pos_q <= '0;
                                phase <= PH_EXT;
                            end else if (req_q.keep_sel) begin
                                done_q <= 1'b1;
                                phase  <= PH_IDLE;
                            end else begin
                                cs_q  <= 1'b1;
                                phase <= PH_TAIL;
                            end
                        end else if (poll_last) begin
                            r1_q  <= xfer_rx;
                            to_q  <= 1'b1;
                            cs_q  <= 1'b1;
                            phase <= PH_TAIL;
                        end
                    end
                    PH_EXT: begin
                        if (pos_q == 3'(EXT_BYTES - 1)) begin
                            if (req_q.keep_sel) begin
                                done_q <= 1'b1;
                                phase  <= PH_IDLE;
                            end else begin
                                cs_q  <= 1'b1;
                                phase <= PH_TAIL;
                            end
                        end else begin
                            pos_q <= pos_q + 1'b1;
                        end
                    end
                    PH_TAIL: begin
                        done_q <= 1'b1;
                        phase  <= PH_IDLE;
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign busy       = (phase != PH_IDLE);
    assign xfer_start = start_q;
    assign xfer_tx    = tx_q;
    assign cs_n       = cs_q;
    assign done       = done_q;
    assign resp_r1    = r1_q;
    assign timed_out  = to_q;

endmodule

// File: rtl/sdspi_cmd_unit_chk.sv
module sdspi_cmd_unit_chk
    import sdcmd_pkg::*;
#(
    parameter int POLL_LIMIT = 5000,
    localparam int PCW = $clog2(POLL_LIMIT + 1)
) (
    input logic           clk,
    input logic           rst,
    input logic           xfer_start,
    input logic [7:0]     xfer_tx,
    input logic           xfer_done,
    input logic           cs_n,
    input logic           done,
    input logic           busy,
    input logic [7:0]     resp_r1,
    input logic           timed_out,
    input phase_t         phase,
    input logic [2:0]     pos_q,
    input cmd_req_t       req_q,
    input logic [PCW-1:0] poll_cnt
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (rst)             outstanding <= 1'b0;
        else if (xfer_start) outstanding <= 1'b1;
        else if (xfer_done)  outstanding <= 1'b0;
    end

    // R1 R2
    first_frame_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (xfer_start && phase == PH_FRAME && pos_q == 3'd0) |-> (!cs_n && xfer_tx[7:6] == 2'b01));

    // R4
    reply_msb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !timed_out) |-> !resp_r1[7]);

    // R5
    poll_bound_chk: assert property (@(posedge clk) disable iff (rst)
        poll_cnt <= PCW'(POLL_LIMIT));

    // R7
    keep_selected_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !timed_out && req_q.keep_sel) |-> !cs_n);

    // R8
    timeout_release_chk: assert property (@(posedge clk) disable iff (rst)
        (done && timed_out) |-> cs_n);

    // R10
    single_xfer_chk: assert property (@(posedge clk) disable iff (rst)
        outstanding |-> !xfer_start);

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy ##1 !done));

endmodule

bind sdspi_cmd_unit sdspi_cmd_unit_chk #(.POLL_LIMIT(POLL_LIMIT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .xfer_start (xfer_start),
    .xfer_tx    (xfer_tx),
    .xfer_done  (xfer_done),
    .cs_n       (cs_n),
    .done       (done),
    .busy       (busy),
    .resp_r1    (resp_r1),
    .timed_out  (timed_out),
    .phase      (phase),
    .pos_q      (pos_q),
    .req_q      (req_q),
    .poll_cnt   (poll_cnt)
);

// File: tb/sdspi_cmd_unit_test.sv
module sdspi_cmd_unit_test;
    localparam int LIMIT = 5000;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [5:0]  req_index;
    logic [31:0] req_arg;
    logic        req_ext, req_keep;
    logic        busy, xfer_start, xfer_done, cs_n, done, timed_out;
    logic [7:0]  xfer_tx, xfer_rx, resp_r1;
    logic [31:0] resp_ext;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    // card model controls
    int         c_pd;
    logic [7:0] c_r1, c_fill;
    logic [31:0] c_ev;
    int         c_lat;
    // card model observations
    int         n, bad_fill, cs_hi, wait_c;
    logic       last_cs;
    logic [7:0] logb [6];
    logic [7:0] resp_q;

    always #5 clk = ~clk;

    sdspi_cmd_unit #(.POLL_LIMIT(LIMIT)) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_index(req_index),
        .req_arg(req_arg), .req_ext(req_ext), .req_keep(req_keep), .busy(busy),
        .xfer_start(xfer_start), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
        .xfer_rx(xfer_rx), .cs_n(cs_n), .done(done), .resp_r1(resp_r1),
        .resp_ext(resp_ext), .timed_out(timed_out)
    );

    function automatic logic [7:0] card_byte(input int k);
        if (k < 6)              return 8'hFF;
        if (k < 6 + c_pd)       return c_fill;
        if (k == 6 + c_pd)      return c_r1;
        if (k <= 6 + c_pd + 4)  return 8'(c_ev >> (8 * (3 - (k - 7 - c_pd))));
        return 8'hFF;
    endfunction

    always @(posedge clk) begin
        xfer_done <= 1'b0;
        if (rst) begin
            n <= 0; bad_fill <= 0; cs_hi <= 0; wait_c <= 0; last_cs <= 1'b1;
            xfer_rx <= 8'hFF; resp_q <= 8'hFF;
        end else if (req_valid && !busy) begin
            n <= 0; bad_fill <= 0; cs_hi <= 0;
        end else if (xfer_start) begin
            if (n < 6) logb[n] <= xfer_tx;
            else if (xfer_tx != 8'hFF) bad_fill <= bad_fill + 1;
            if (cs_n) cs_hi <= cs_hi + 1;
            last_cs <= cs_n;
            resp_q  <= card_byte(n);
            n       <= n + 1;
            wait_c  <= c_lat;
        end else if (wait_c != 0) begin
            wait_c <= wait_c - 1;
            if (wait_c == 1) begin
                xfer_done <= 1'b1;
                xfer_rx   <= resp_q;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [5:0] idx, input logic [31:0] arg, input bit ext,
                           input bit keep, input int pd, input logic [7:0] r1,
                           input logic [7:0] fill, input logic [31:0] ev, input int lat);
        int  waited = 0;
        bit  to_exp;
        int  exp_n;
        c_pd = pd; c_r1 = r1; c_fill = fill; c_ev = ev; c_lat = lat;
        @(negedge clk);
        req_valid = 1'b1; req_index = idx; req_arg = arg; req_ext = ext; req_keep = keep;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!cs_n && busy, "R1 select on accept", {30'd0, cs_n, busy}, 32'd1);
        while (!done && waited < 60000) begin
            @(negedge clk);
            waited++;
        end
        to_exp = (pd >= LIMIT);
        chk(done, "R11 done reached", {31'd0, done}, 32'd1);
        chk(logb[0] == {2'b01, idx}, "R2 first frame byte", logb[0], {2'b01, idx});
        chk({logb[1], logb[2], logb[3], logb[4]} == arg, "R3 argument order",
            {logb[1], logb[2], logb[3], logb[4]}, arg);
        chk(logb[5] == ((idx == 6'd8) ? 8'h87 : 8'h95), "R3 crc byte", logb[5],
            (idx == 6'd8) ? 8'h87 : 8'h95);
        chk(bad_fill == 0, "R4 poll bytes are 0xFF", bad_fill, 0);
        chk(timed_out == to_exp, "R5 timeout flag", timed_out, to_exp);
        if (to_exp) begin
            exp_n = 6 + LIMIT + 1;
            chk(n == exp_n, "R5 R8 exchange count on timeout", n, exp_n);
            chk(cs_n && cs_hi == 1 && last_cs, "R8 release on timeout",
                {cs_hi[29:0], cs_n, last_cs}, 32'h7);
        end else begin
            chk(resp_r1 == r1, "R4 reply byte", resp_r1, r1);
            if (ext) chk(resp_ext == ev, "R9 extended word", resp_ext, ev);
            exp_n = 6 + pd + 1 + (ext ? 4 : 0) + (keep ? 0 : 1);
            chk(n == exp_n, keep ? "R7 exchange count" : "R6 exchange count", n, exp_n);
            if (keep)
                chk(!cs_n && cs_hi == 0, "R7 card stays selected",
                    {cs_hi[30:0], cs_n}, 32'd0);
            else
                chk(cs_n && cs_hi == 1 && last_cs, "R6 one trailing byte deselected",
                    {cs_hi[29:0], cs_n, last_cs}, 32'h7);
        end
        @(negedge clk);
        chk(!done && !busy, "R11 done is one pulse", {30'd0, done, busy}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_index = '0; req_arg = '0;
        req_ext = 1'b0; req_keep = 1'b0;
        c_pd = 0; c_r1 = 0; c_fill = 8'hFF; c_ev = 0; c_lat = 1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && !busy && !done && !xfer_start, "R11 reset state",
            {28'd0, cs_n, busy, done, xfer_start}, 32'h8);

        // sweep all indices, varied filler, reply, extended flag, latency (R10 via handshake)
        for (int i = 0; i < 64; i++) begin
            run_cmd(6'(i), 32'(i) * 32'h0101_0101 ^ 32'hA5C3_1E78, i[0], 1'b0,
                    i % 5, 8'(i) & 8'h7F, 8'h80 | 8'(i * 7), 32'hC0DE_0000 + 32'(i * 257),
                    1 + (i % 3));
        end

        // keep mode, with and without extended bytes, then a normal command
        run_cmd(6'd9, 32'h0, 1'b0, 1'b1, 3, 8'h00, 8'hFF, 32'h0, 2);
        run_cmd(6'd58, 32'h0, 1'b1, 1'b1, 1, 8'h01, 8'hBF, 32'h40FF_8000, 1);
        run_cmd(6'd8, 32'h0000_01AA, 1'b1, 1'b0, 2, 8'h05, 8'h80, 32'h0000_01AA, 3);

        // poll window edges
        run_cmd(6'd41, 32'h4000_0000, 1'b0, 1'b0, LIMIT - 1, 8'h7E, 8'hFF, 32'h0, 1);
        run_cmd(6'd0, 32'h0, 1'b0, 1'b0, LIMIT, 8'h01, 8'hFF, 32'h0, 1);
        run_cmd(6'd17, 32'h0000_1200, 1'b0, 1'b1, LIMIT, 8'h00, 8'hC3, 32'h0, 1);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule